// File: doc/BRIEF.md
# Backplane Node Register Window Decoder

This block answers register-bus accesses aimed at the per-slot configuration space of a backplane with up to sixteen nodes. Each node owns a fixed-size byte window. The upper address bits select the node and the lower bits select a register inside that node's window. For every node that is populated, the block reports a read-only device-type code and keeps one writable control/status register. It also returns a constant pattern from one status offset. Accesses to a node above the highest populated node number get an error response instead of an acknowledge.

A requester raises `req_i` for one cycle with the address, the direction and the write data. Exactly one cycle later the block pulses either `ack_o` or `err_o`, and read data is valid on `rdata_o` in that cycle. The highest populated node and the type code of each slot are parameters. The bench and all examples use the defaults: a 0x2000-byte window, 16 slots, populated nodes 0 to 3, and type codes 0x0000, 0x010E, 0x0102 and 0x0000 for nodes 0 to 3.

Top module: `bkp_node_window`

## Requirements
- R1: The 17-bit address splits into node = addr[16:13] (address divided by 0x2000) and offset = addr[12:0] (address modulo 0x2000). The full 13-bit offset is decoded, so offset 0x1004 is not the control register.
- R2: A read at offset 0x000 of a populated node returns that node's type code, zero-extended to 32 bits. A code of 0 marks an empty slot.
- R3: A write to offset 0x000 is acknowledged and discarded. Later reads of the type code and of every control register are unchanged.
- R4: A read at offset 0x004 returns the stored control register with bits [3:0] replaced by the node number.
- R5: A write at offset 0x004 stores the written value in that node's control register. Bits [31:4] read back as written, and no other node's register changes.
- R6: An access of either direction to a node number greater than the highest populated node gets `err_o`, no `ack_o`, read data 0 and no state change.
- R7: A read at offset 0x0F4 of a populated node returns 0x0000FFFF.
- R8: Any other offset of a populated node reads 0 with `ack_o`, and writes to it change nothing.
- R9: Each request gets exactly one response one cycle later, either `ack_o` or `err_o`, never both. No response appears without a request, and read data is 0 for writes.
- R10: After reset, `ack_o` and `err_o` are low and every control register holds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Byte address: node in [16:13], offset in [12:0] |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access accepted, one cycle after the request |
| err_o | output | 1 | No node at that slot, one cycle after the request |
| rdata_o | output | 32 | Read data, valid with ack_o |

## Verification
Checks that run on every cycle cover the response protocol: a single response one cycle after each request, never both flags, and silence when idle. They also cover the error response for absent nodes, the node number in the low field of control-register reads, the constant status pattern, and the rule that a control register changes only when a write hits its own node. The stored contents of the registers, writes to other nodes leaving a register alone, discarded type-register and unknown-offset writes, offset aliasing and the reset contents need sequences of accesses. Only the bench scenarios can show these, by comparing against a reference model.

// File: rtl/bkp_win_pkg.sv
package bkp_win_pkg;
  localparam int TYPE_W   = 16;
  localparam int OFF_TYPE = 'h000;
  localparam int OFF_CSR  = 'h004;
  localparam int OFF_STAT = 'h0F4;
  localparam logic [31:0] STAT_VAL = 32'h0000_FFFF;
endpackage

// File: rtl/bkp_addr_split.sv
module bkp_addr_split #(
  parameter int NODE_W   = 4,
  parameter int OFF_W    = 13,
  parameter int MAX_NODE = 3
) (
  input  logic [NODE_W+OFF_W-1:0] addr_i,
  output logic [NODE_W-1:0]       node_o,
  output logic [OFF_W-1:0]        off_o,
  output logic                    present_o
);
  localparam logic [NODE_W-1:0] MAX_N = NODE_W'(MAX_NODE);

  assign node_o    = addr_i[NODE_W+OFF_W-1:OFF_W];
  assign off_o     = addr_i[OFF_W-1:0];
  assign present_o = (node_o <= MAX_N);
endmodule

// File: rtl/bkp_csr_bank.sv
module bkp_csr_bank #(
  parameter int NODES    = 16,
  parameter int NODE_W   = 4,
  parameter int HI_W     = 28,
  parameter int MAX_NODE = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [NODE_W-1:0]           wr_node_i,
  input  logic [HI_W-1:0]             wr_hi_i,
  output logic [NODES-1:0][HI_W-1:0]  hi_o
);
  for (genvar n = 0; n < NODES; n++) begin : g_node
    if (n <= MAX_NODE) begin : g_live
      logic [HI_W-1:0] hi_q;
      logic            hit;
      assign hit = wr_en_i && (wr_node_i == NODE_W'(n));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  hi_q <= '0;
        else if (hit) hi_q <= wr_hi_i;
      end
      assign hi_o[n] = hi_q;

      // R3, R5: register moves only on a write aimed at this node
      a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && wr_node_i == NODE_W'(n)) |=> $stable(hi_o[n]));
    end else begin : g_dead
      assign hi_o[n] = '0;
    end
  end
endmodule

// File: rtl/bkp_node_window.sv
module bkp_node_window
  import bkp_win_pkg::*;
#(
  parameter int NODES     = 16,
  parameter int WIN_BYTES = 'h2000,
  parameter int DATA_W    = 32,
  parameter int MAX_NODE  = 3,
  parameter logic [NODES*TYPE_W-1:0] NODE_TYPES =
    {{12{16'h0000}}, 16'h0000, 16'h0102, 16'h010E, 16'h0000},
  localparam int NODE_W = $clog2(NODES),
  localparam int OFF_W  = $clog2(WIN_BYTES),
  localparam int ADDR_W = NODE_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HI_W = DATA_W - NODE_W;
  localparam logic [OFF_W-1:0] O_TYPE = OFF_W'(OFF_TYPE);
  localparam logic [OFF_W-1:0] O_CSR  = OFF_W'(OFF_CSR);
  localparam logic [OFF_W-1:0] O_STAT = OFF_W'(OFF_STAT);

  logic [NODE_W-1:0]           node;
  logic [OFF_W-1:0]            off;
  logic                        present;
  logic [NODES-1:0][HI_W-1:0]  csr_hi;
  logic                        csr_wr;
  logic [DATA_W-1:0]           rd_d;
  logic [TYPE_W-1:0]           type_code;

  bkp_addr_split #(.NODE_W(NODE_W), .OFF_W(OFF_W), .MAX_NODE(MAX_NODE)) u_split (
    .addr_i    (addr_i),
    .node_o    (node),
    .off_o     (off),
    .present_o (present)
  );

  assign csr_wr = req_i && we_i && present && (off == O_CSR);

  bkp_csr_bank #(.NODES(NODES), .NODE_W(NODE_W), .HI_W(HI_W), .MAX_NODE(MAX_NODE)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (csr_wr),
    .wr_node_i (node),
    .wr_hi_i   (wdata_i[DATA_W-1:NODE_W]),
    .hi_o      (csr_hi)
  );

  assign type_code = NODE_TYPES[node*TYPE_W +: TYPE_W];

  always_comb begin
    rd_d = '0;
    if (present && !we_i) begin
      unique case (off)
        O_TYPE:  rd_d = DATA_W'(type_code);
        O_CSR:   rd_d = {csr_hi[node], node};
        O_STAT:  rd_d = DATA_W'(STAT_VAL);
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= req_i && present;
      err_o   <= req_i && !present;
      rdata_o <= req_i ? rd_d : '0;
    end
  end

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && err_o));
  a_r9_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (ack_o || err_o));
  a_r9_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !(ack_o || err_o));
  a_r6_absent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[ADDR_W-1:OFF_W] > NODE_W'(MAX_NODE)) |=> (err_o && rdata_o == '0));
  a_r4_node_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && present && off == O_CSR) |=>
      (rdata_o[NODE_W-1:0] == $past(addr_i[ADDR_W-1:OFF_W])));
  a_r7_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && present && addr_i[OFF_W-1:0] == O_STAT) |=>
      (ack_o && rdata_o == DATA_W'(STAT_VAL)));
endmodule

// File: tb/bkp_node_window_test.sv
module bkp_node_window_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [255:0] TYPES =
    {{12{16'h0000}}, 16'h0000, 16'h0102, 16'h010E, 16'h0000};
  localparam int LAST = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [16:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        ack, err;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [27:0] m_hi [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  bkp_node_window #(.MAX_NODE(LAST), .NODE_TYPES(TYPES)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .err_o(err), .rdata_o(rdata)
  );

  function automatic logic [31:0] model_rd(int node, int off);
    case (off)
      'h000:   return {16'h0, TYPES[node*16 +: 16]};
      'h004:   return {m_hi[node], 4'(node)};
      'h0F4:   return 32'h0000_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one access, starting and ending at a falling edge; checks response against model
  task automatic access(string tag, bit w, int node, int off, logic [31:0] wd);
    logic [31:0] exp_rd;
    bit pres;
    pres = node <= LAST;
    exp_rd = (!pres || w) ? 32'h0 : model_rd(node, off);
    req = 1'b1; we = w; addr = {4'(node), 13'(off)}; wdata = wd;
    @(posedge clk); @(negedge clk);
    check({tag, " ack/err"}, {30'h0, ack, err}, {30'h0, pres, !pres});
    check({tag, " rdata"}, rdata, exp_rd);
    req = 1'b0; we = 1'b0;
    if (w && pres && off == 'h004) m_hi[node] = wd[31:4];
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R9 idle", {30'h0, ack, err}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_hi[i] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R10 reset ack/err", {30'h0, ack, err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 quiet after reset", {30'h0, ack, err}, 32'h0);
    for (int n = 0; n <= LAST; n++) access("R10 csr zero", 0, n, 'h004, 0);

    // directed corners
    access("R2 type node1", 0, 1, 'h000, 0);
    access("R2 empty node3", 0, 3, 'h000, 0);
    access("R5 write node2", 1, 2, 'h004, 32'hDEAD_BEEF);
    access("R4 read node2", 0, 2, 'h004, 0);
    access("R5 node1 untouched", 0, 1, 'h004, 0);
    access("R1 offset alias", 0, 2, 'h1004, 0);
    access("R1 top node present", 0, 3, 'h0F4, 0);
    access("R3 type write", 1, 1, 'h000, 32'h1234_5678);
    access("R3 type after write", 0, 1, 'h000, 0);
    access("R6 absent write", 1, 4, 'h004, 32'hFFFF_FFF0);
    access("R6 absent read", 0, 15, 'h000, 0);
    access("R7 status", 0, 0, 'h0F4, 0);
    access("R8 write unknown", 1, 0, 'h008, 32'hFFFF_FFFF);
    access("R8 read unknown", 0, 0, 'h008, 0);
    idle_check();

    // constrained random
    for (int k = 0; k < 600; k++) begin
      int sel, node, off;
      bit w;
      string tag;
      sel  = int'($urandom % 8);
      node = ($urandom % 2 == 0) ? int'($urandom % 4) : int'($urandom % 16);
      w    = ($urandom % 3) == 0;
      case (sel)
        0, 1:    off = 'h000;
        2, 3, 4: off = 'h004;
        5:       off = 'h0F4;
        default: off = int'($urandom % 'h2000);
      endcase
      if (node > LAST)        tag = "R6 rnd absent";
      else if (off == 'h000)  tag = w ? "R3 rnd type wr" : "R2 rnd type rd";
      else if (off == 'h004)  tag = w ? "R5 rnd csr wr" : "R4 rnd csr rd";
      else if (off == 'h0F4 && !w) tag = "R7 rnd status";
      else                    tag = "R8 rnd other";
      access(tag, w, node, off, $urandom);
      if ($urandom % 5 == 0) idle_check();
    end
    for (int n = 0; n <= LAST; n++) access("R5 final csr", 0, n, 'h004, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule